// File: doc/BRIEF.md
# Bunch-by-Bunch Position Feedback Processor

This block is the digital core of a fast beam-position feedback loop that runs within a single bunch train. A trigger that arrives before the beam arms it. It then takes one sample per bunch from two converter channels, both sampled at one quarter of the core clock. The capture point is timed so that it falls on the peak of the front-end pulse. One channel carries the position, as a difference signal. The other carries the bunch charge, as a sum signal.

For each bunch, the block divides the position by the charge. It does this by multiplying the difference sample by an entry from a reciprocal table, which is indexed by the upper bits of the sum. A writable table then maps the normalised position to a gain-scaled correction. That correction is added to a saturating accumulator, which acts as the delay loop. The accumulator's value is the word sent to the kicker-drive converter.

The first bunch of a train can only be measured, so its correction first acts on the second bunch. A configuration bit skips the normalisation stage to save three core cycles of latency.

Top module: `bunchFeedback`

## Requirements
- R1: While the block is not armed, samples on `diffIn`/`sumIn` are never captured. After reset, `dacOut` is 0 and `armed` is 0.
- R2: A core cycle with `trigIn` high arms the block and restarts the train. It also clears `dacOut` to 0 at that same edge.
- R3: One sample period is 4 core cycles, and counting starts at the trigger edge. Bunch n (counting from 0) is captured at the edge that lies 4*(cfgDelay + n*cfgSpacing + 1) edges after the trigger edge.
- R4: In normalising mode, the table value is r = floor(4096 / (16*floor(sum/16) + 8)). The normalised position is clamp(floor(diff*r/256), -16, 15), where diff is signed and sum is unsigned.
- R5: The gain table holds 32 signed 12-bit entries. Its address is the normalised position taken as a 5-bit two's complement code, so position -1 reads address 31. It is written through `gainWrEn`/`gainWrAddr`/`gainWrData`.
- R6: For each processed bunch, `dacOut` becomes the previous `dacOut` plus the gain table entry. The value is held between bunches.
- R7: In normalising mode, `dacOut` changes 5 edges after the capture edge, and is unchanged 4 edges after it. In bypass mode (`cfgBypassNorm`=1), the position is floor(diff/8) and `dacOut` changes 2 edges after capture, which is exactly 3 edges sooner.
- R8: A train holds `cfgBunches` bunches, from 1 to 60. `armed` falls at the last capture edge, and later input changes leave `dacOut` unchanged.
- R9: The first bunch is only measured: `dacOut` is still 0 right after the first capture edge of a train.
- R10: The accumulator saturates to the range -2048 to 2047 and never wraps around.
- R11: A bunch whose sum sample is below `cfgChargeThr` makes no update, so `dacOut` holds. It still counts as a bunch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Pre-beam trigger; arms the block and clears the loop |
| diffIn | input | 8 | Signed difference (position) sample |
| sumIn | input | 8 | Unsigned sum (charge) sample |
| cfgDelay | input | 8 | Sample periods from trigger to the first bunch |
| cfgSpacing | input | 8 | Sample periods between bunches (at least 1) |
| cfgBunches | input | 6 | Bunches per train, 1 to 60 |
| cfgBypassNorm | input | 1 | 1 skips charge normalisation |
| cfgChargeThr | input | 8 | Minimum sum sample for an update |
| gainWrEn | input | 1 | Gain table write strobe |
| gainWrAddr | input | 5 | Gain table write address |
| gainWrData | input | 12 | Gain table write value, signed |
| dacOut | output | 12 | Signed correction word to the drive converter |
| armed | output | 1 | High while a train is being sampled |

## Verification
The assertions assume that `cfgSpacing` is at least 1, that `cfgBunches` lies between 1 and 60, and that the configuration and gain table stay fixed while a train is in flight. Under those assumptions, at most one capture can occur in any four cycles, and the last capture is the only event that ends a train. The stimulus holds to this. It loads the table only while the block is idle, and it changes the configuration only before a trigger. It uses spacings of two or more periods and drives each bunch's samples before the edge that captures them, so every update can be compared at its exact edge before the next capture arrives.

// File: rtl/bunchFbPkg.sv
package bunchFbPkg;
  // converter sample strobe divides the core clock by this ratio
  localparam int SAMPLE_DIV = 4;
  localparam int PHASE_W = $clog2(SAMPLE_DIV);

  typedef struct packed {
    logic clearAcc;  // restart the loop on a trigger
    logic capture;   // take the current converter samples
  } fbStb_t;
endpackage

// File: rtl/bunchFbCtl.sv
module bunchFbCtl
  import bunchFbPkg::*;
#(
  parameter int PCW = 8,
  parameter int BCW = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigIn,
  input  logic [PCW-1:0] cfgDelay,
  input  logic [PCW-1:0] cfgSpacing,
  input  logic [BCW-1:0] cfgBunches,
  output fbStb_t         stb,
  output logic           armed
);
  localparam int TW = PCW + BCW;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SAMPLE_DIV - 1);

  logic [PHASE_W-1:0] phase;
  logic [TW-1:0]      periodCnt;
  logic [TW-1:0]      target;
  logic [BCW-1:0]     bunchCnt;
  logic               periodEnd;
  logic               hit;

  assign periodEnd = armed && (phase == LAST_PHASE);
  assign hit       = periodEnd && (periodCnt == target);

  always_comb begin
    stb.clearAcc = trigIn;
    stb.capture  = hit && !trigIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      phase     <= '0;
      periodCnt <= '0;
      target    <= '0;
      bunchCnt  <= '0;
    end else if (trigIn) begin
      armed     <= 1'b1;
      phase     <= '0;
      periodCnt <= '0;
      target    <= TW'(cfgDelay);
      bunchCnt  <= '0;
    end else if (armed) begin
      phase <= phase + 1'b1;
      if (periodEnd) periodCnt <= periodCnt + 1'b1;
      if (hit) begin
        target   <= target + TW'(cfgSpacing);
        bunchCnt <= bunchCnt + 1'b1;
        if ((bunchCnt + 1'b1) == cfgBunches) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bunchFbRecipRom.sv
module bunchFbRecipRom #(
  parameter int DW   = 8,
  parameter int IDXW = 4,
  parameter int RECW = 10
) (
  input  logic            clk,
  input  logic [IDXW-1:0] idx,
  output logic [RECW-1:0] recipQ
);
  localparam int DEPTH  = 1 << IDXW;
  localparam int BUCKET = 1 << (DW - IDXW);
  localparam int HALF   = BUCKET / 2;
  localparam int NUM    = HALF << (RECW - 1);

  logic [RECW-1:0] tbl [DEPTH];

  // each entry is the reciprocal of its bucket's midpoint
  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    localparam int VAL = NUM / (i * BUCKET + HALF);
    assign tbl[i] = RECW'(VAL);
  end

  always_ff @(posedge clk) recipQ <= tbl[idx];
endmodule

// File: rtl/bunchFbDatapath.sv
module bunchFbDatapath
  import bunchFbPkg::*;
#(
  parameter int DW      = 8,
  parameter int IDXW    = 4,
  parameter int RECW    = 10,
  parameter int NORM_SH = 8,
  parameter int NW      = 5,
  parameter int GW      = 12,
  parameter int OW      = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fbStb_t               stb,
  input  logic signed [DW-1:0] diffIn,
  input  logic [DW-1:0]        sumIn,
  input  logic                 cfgBypassNorm,
  input  logic [DW-1:0]        cfgChargeThr,
  input  logic                 gainWrEn,
  input  logic [NW-1:0]        gainWrAddr,
  input  logic signed [GW-1:0] gainWrData,
  output logic signed [OW-1:0] dacOut
);
  localparam int PW     = DW + RECW + 1;
  localparam int AW     = OW + 1;
  localparam int GDEPTH = 1 << NW;
  localparam logic signed [PW-1:0] NMAX = PW'((1 <<< (NW - 1)) - 1);
  localparam logic signed [PW-1:0] NMIN = ~NMAX;
  localparam logic signed [AW-1:0] AMAX = AW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] AMIN = ~AMAX;

  // capture stage
  logic signed [DW-1:0] capDiff;
  logic [IDXW-1:0]      capSumHi;
  logic                 capVld, capSkip;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAcc) begin
      capDiff  <= '0;
      capSumHi <= '0;
      capVld   <= 1'b0;
      capSkip  <= 1'b0;
    end else begin
      capVld <= stb.capture;
      if (stb.capture) begin
        capDiff  <= diffIn;
        capSumHi <= sumIn[DW-1 -: IDXW];
        capSkip  <= (sumIn < cfgChargeThr);
      end
    end
  end

  // normalisation: table read, multiply, scale and clamp (3 stages)
  logic [RECW-1:0]      recipQ;
  logic signed [DW-1:0] n1Diff;
  logic signed [PW-1:0] prodQ;
  logic signed [PW-1:0] prodShift;
  logic signed [NW-1:0] normQ;
  logic [2:0]           nVld, nSkip;

  bunchFbRecipRom #(.DW(DW), .IDXW(IDXW), .RECW(RECW)) uRecip (
    .clk(clk), .idx(capSumHi), .recipQ(recipQ)
  );

  assign prodShift = prodQ >>> NORM_SH;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAcc) begin
      n1Diff <= '0;
      prodQ  <= '0;
      normQ  <= '0;
      nVld   <= '0;
      nSkip  <= '0;
    end else begin
      n1Diff <= capDiff;
      prodQ  <= $signed({{(PW-DW){n1Diff[DW-1]}}, n1Diff})
              * $signed({{(PW-RECW){1'b0}}, recipQ});
      if (prodShift > NMAX)      normQ <= NMAX[NW-1:0];
      else if (prodShift < NMIN) normQ <= NMIN[NW-1:0];
      else                       normQ <= prodShift[NW-1:0];
      nVld  <= {nVld[1:0], capVld};
      nSkip <= {nSkip[1:0], capSkip};
    end
  end

  // gain lookup and delay-loop accumulator
  logic signed [GW-1:0] gainTbl [GDEPTH];
  logic signed [GW-1:0] gainQ;
  logic [NW-1:0]        gIdx;
  logic                 gVld, gainVld;
  logic signed [AW-1:0] accSum;

  always_comb begin
    if (cfgBypassNorm) begin
      gIdx = capDiff[DW-1 -: NW];
      gVld = capVld && !capSkip;
    end else begin
      gIdx = normQ;
      gVld = nVld[2] && !nSkip[2];
    end
  end

  always_ff @(posedge clk) begin
    if (gainWrEn) gainTbl[gainWrAddr] <= gainWrData;
  end

  assign accSum = $signed({dacOut[OW-1], dacOut})
                + $signed({{(AW-GW){gainQ[GW-1]}}, gainQ});

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAcc) begin
      gainQ   <= '0;
      gainVld <= 1'b0;
      dacOut  <= '0;
    end else begin
      gainQ   <= gainTbl[gIdx];
      gainVld <= gVld;
      if (gainVld) begin
        if (accSum > AMAX)      dacOut <= AMAX[OW-1:0];
        else if (accSum < AMIN) dacOut <= AMIN[OW-1:0];
        else                    dacOut <= accSum[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/bunchFeedback.sv
module bunchFeedback
  import bunchFbPkg::*;
#(
  parameter int DW      = 8,
  parameter int IDXW    = 4,
  parameter int RECW    = 10,
  parameter int NORM_SH = 8,
  parameter int NW      = 5,
  parameter int GW      = 12,
  parameter int OW      = 12,
  parameter int PCW     = 8,
  parameter int BCW     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigIn,
  input  logic signed [DW-1:0] diffIn,
  input  logic [DW-1:0]        sumIn,
  input  logic [PCW-1:0]       cfgDelay,
  input  logic [PCW-1:0]       cfgSpacing,
  input  logic [BCW-1:0]       cfgBunches,
  input  logic                 cfgBypassNorm,
  input  logic [DW-1:0]        cfgChargeThr,
  input  logic                 gainWrEn,
  input  logic [NW-1:0]        gainWrAddr,
  input  logic signed [GW-1:0] gainWrData,
  output logic signed [OW-1:0] dacOut,
  output logic                 armed
);
  fbStb_t stb;

  bunchFbCtl #(.PCW(PCW), .BCW(BCW)) uCtl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .cfgDelay(cfgDelay), .cfgSpacing(cfgSpacing), .cfgBunches(cfgBunches),
    .stb(stb), .armed(armed)
  );

  bunchFbDatapath #(
    .DW(DW), .IDXW(IDXW), .RECW(RECW), .NORM_SH(NORM_SH),
    .NW(NW), .GW(GW), .OW(OW)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .diffIn(diffIn), .sumIn(sumIn),
    .cfgBypassNorm(cfgBypassNorm), .cfgChargeThr(cfgChargeThr),
    .gainWrEn(gainWrEn), .gainWrAddr(gainWrAddr), .gainWrData(gainWrData),
    .dacOut(dacOut)
  );
endmodule

// File: rtl/bunchFeedbackChk.sv
module bunchFeedbackChk #(
  parameter int OW = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trigIn,
  input logic                 armed,
  input logic                 capture,
  input logic signed [OW-1:0] dacOut
);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = ~MAXV;

  // R2: a trigger zeroes the correction word
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |=> (dacOut == '0));

  // R10: positive full scale never wraps to negative full scale
  a_r10_no_wrap_hi: assert property (@(posedge clk) disable iff (!rstN)
    (dacOut == MAXV) |=> (dacOut != MINV));

  // R10: negative full scale never wraps to positive full scale
  a_r10_no_wrap_lo: assert property (@(posedge clk) disable iff (!rstN)
    (dacOut == MINV) |=> (dacOut != MAXV));

  // R8: a train ends only on a capture
  a_r8_end_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(capture));

  // R3: captures are at least one sample period apart
  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !capture);
endmodule

bind bunchFeedback bunchFeedbackChk #(.OW(OW)) uChk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .armed(armed),
  .capture(stb.capture), .dacOut(dacOut)
);

// File: tb/bunchFeedback_test.sv
module bunchFeedback_test;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              trigIn = 1'b0;
  logic signed [7:0] diffIn = '0;
  logic [7:0]        sumIn = '0;
  logic [7:0]        cfgDelay = '0;
  logic [7:0]        cfgSpacing = 8'd2;
  logic [5:0]        cfgBunches = 6'd3;
  logic              cfgBypassNorm = 1'b0;
  logic [7:0]        cfgChargeThr = '0;
  logic              gainWrEn = 1'b0;
  logic [4:0]        gainWrAddr = '0;
  logic signed [11:0] gainWrData = '0;
  logic signed [11:0] dacOut;
  logic              armed;

  int nChecks = 0;
  int nFail = 0;
  int dArr[64];
  int sArr[64];

  bunchFeedback uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .diffIn(diffIn), .sumIn(sumIn),
    .cfgDelay(cfgDelay), .cfgSpacing(cfgSpacing), .cfgBunches(cfgBunches),
    .cfgBypassNorm(cfgBypassNorm), .cfgChargeThr(cfgChargeThr),
    .gainWrEn(gainWrEn), .gainWrAddr(gainWrAddr), .gainWrData(gainWrData),
    .dacOut(dacOut), .armed(armed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gainRef(input int pos);
    return pos * 37 - 5;
  endfunction

  function automatic int clampI(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // R4 / R7 reference position
  function automatic int posRef(input int d, input int s, input bit byp);
    int r;
    if (byp) return d >>> 3;
    r = 4096 / ((s / 16) * 16 + 8);
    return clampI((d * r) >>> 8, -16, 15);
  endfunction

  task automatic runTrain(input int delay, input int sp, input int nb,
                          input bit byp, input int thr);
    int cur;
    int expV;
    int prevV;
    int lat;
    lat = byp ? 2 : 5;
    @(negedge clk);
    cfgDelay = 8'(delay);
    cfgSpacing = 8'(sp);
    cfgBunches = 6'(nb);
    cfgBypassNorm = byp;
    cfgChargeThr = 8'(thr);
    trigIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trigIn = 1'b0;
    check(int'(dacOut), 0, "R2 cleared on trigger");
    check(int'(armed), 1, "R2 armed after trigger");
    expV = 0;
    cur = 0;
    for (int n = 0; n < nb; n++) begin
      int c;
      c = 4 * (delay + n * sp + 1);
      diffIn = 8'(dArr[n]);
      sumIn = 8'(sArr[n]);
      repeat (c - cur) @(posedge clk);
      @(negedge clk);
      cur = c;
      if (n == 0) check(int'(dacOut), 0, "R9 first bunch uncorrected");
      prevV = expV;
      if (sArr[n] >= thr)
        expV = clampI(expV + gainRef(posRef(dArr[n], sArr[n], byp)), -2048, 2047);
      repeat (lat - 1) @(posedge clk);
      @(negedge clk);
      check(int'(dacOut), prevV, "R7 not yet updated");
      @(posedge clk);
      @(negedge clk);
      if (sArr[n] < thr) check(int'(dacOut), expV, "R11 low charge hold");
      else check(int'(dacOut), expV, byp ? "R6 bypass update" : "R4 R5 R6 update");
      cur += lat;
    end
    check(int'(armed), 0, "R8 disarmed after last bunch");
    diffIn = 8'sd100;
    sumIn = 8'd30;
    repeat (24) @(posedge clk);
    @(negedge clk);
    check(int'(dacOut), expV, "R8 inputs ignored after train");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(int'(dacOut), 0, "R1 reset output");
    check(int'(armed), 0, "R1 reset idle");

    // R5: load the gain table while idle
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      gainWrEn = 1'b1;
      gainWrAddr = 5'(a);
      gainWrData = 12'(gainRef(a >= 16 ? a - 32 : a));
    end
    @(negedge clk);
    gainWrEn = 1'b0;

    // R1: samples before any trigger do nothing
    diffIn = 8'sd120;
    sumIn = 8'd40;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(int'(dacOut), 0, "R1 no processing before trigger");
    check(int'(armed), 0, "R1 still idle");

    // R3 R4 R6 R7: sweep patterns in both modes
    for (int byp = 0; byp < 2; byp++) begin
      for (int t = 0; t < 6; t++) begin
        for (int n = 0; n < 8; n++) begin
          dArr[n] = ((n * 53 + t * 29) % 256) - 128;
          sArr[n] = 16 + ((n * 71 + t * 13) % 240);
        end
        runTrain(t % 3, 2 + (t % 2), 8, byp[0], 0);
      end
    end

    // R11: charge threshold
    for (int n = 0; n < 6; n++) begin
      dArr[n] = 90 - n * 30;
      sArr[n] = (n % 2 == 0) ? 50 : 200;
    end
    runTrain(1, 2, 6, 1'b0, 100);

    // R10: positive then negative saturation
    for (int n = 0; n < 20; n++) begin
      dArr[n] = 127;
      sArr[n] = 20;
    end
    runTrain(0, 2, 20, 1'b0, 0);
    for (int n = 0; n < 20; n++) begin
      dArr[n] = -128;
      sArr[n] = 20;
    end
    runTrain(2, 2, 20, 1'b1, 0);

    // R8: longest train, mixed directions
    for (int n = 0; n < 60; n++) begin
      dArr[n] = (n < 12) ? 127 : -((n * 7) % 128);
      sArr[n] = 20 + (n * 3) % 200;
    end
    runTrain(3, 2, 60, 1'b0, 0);

    // R3: three-bunch train at wider spacing
    dArr[0] = 40; dArr[1] = -70; dArr[2] = 15;
    sArr[0] = 60; sArr[1] = 130; sArr[2] = 255;
    runTrain(5, 4, 3, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule